// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns one operand reference of a real-mode segmented machine into a 20-bit physical memory address. It keeps six 16-bit segment registers (code, stack, and four data windows) that are loaded through a single write port. A request carries an addressing-mode code, two register choices, the general registers that can take part in the effective address, a 16-bit displacement and an optional segment override.

The block first forms a 16-bit effective address from the low halves of the 32-bit general registers and the displacement. It then picks a segment: the stack window when BP takes part in the sum, otherwise the data window, unless an override names another register. The physical address is that segment value shifted left by four bits plus the offset.

The result comes out registered one cycle after the request strobe, together with a valid flag. An I/O request skips segmentation and returns its 16-bit port number in a separate address space, marked by its own flag. Illegal register combinations raise an error flag in place of valid.

Top module: `rm_addr_gen`

## Requirements
- R1: One cycle after a memory request, `out_valid` is 1 and `out_addr` equals (segment << 4) + offset, taken modulo 2^20.
- R2: Only bits [15:0] of each 32-bit general register feed the offset; bits [31:16] have no effect.
- R3: Mode codes set the offset. 0 is the displacement. 1 is register A alone. 2 is register A plus the displacement. 3 is base A plus index B. 4 is base A plus index B plus the displacement. Register codes are 0=BX, 1=BP, 2=SI, 3=DI.
- R4: The offset sum wraps modulo 2^16 before the segment base is added.
- R5: With no override, the stack segment is used when BP is one of the registers summed, and the data segment is used in every other case, including mode 0.
- R6: When `req_ovr_en` is 1, the segment named by `req_ovr_sel` replaces the default. The codes are 0=code, 1=stack, 2=data, 3=extra, 4=F, 5=G.
- R7: A write with `seg_wr_sel` 0..5 loads that segment register from the next cycle on. A write with code 6 or 7 changes no segment register.
- R8: A request issued in the same cycle as a segment write uses the old segment value; the new value applies from the next request.
- R9: An I/O request gives `out_io`=1, `out_valid`=0, and `out_addr` equal to the 16-bit port zero-extended, with no segment added.
- R10: `out_err`=1 and `out_valid`=0 in any of these cases: mode code 5..7; mode 3 or 4 with register A not BX/BP or register B not SI/DI; an override code of 6 or 7.
- R11: Two segment:offset pairs that describe the same location give the same physical address (002BH:0013H and 002CH:0003H both give 002C3H).
- R12: After reset all flags and `out_addr` are 0, and every segment register is 0. A cycle with no request gives all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 3 | Segment register to write (0..5) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Request strobe |
| req_io | input | 1 | Request is an I/O port access |
| req_mode | input | 3 | Addressing-mode code |
| req_reg_a | input | 2 | Register A (base, or the single register) |
| req_reg_b | input | 2 | Register B (index) |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_sel | input | 3 | Override segment code |
| req_disp | input | 16 | Displacement |
| req_port | input | 16 | I/O port number |
| gpr_bx | input | 32 | BX-holding general register |
| gpr_bp | input | 32 | BP-holding general register |
| gpr_si | input | 32 | SI-holding general register |
| gpr_di | input | 32 | DI-holding general register |
| out_valid | output | 1 | Physical address valid |
| out_io | output | 1 | Output holds an I/O port number |
| out_err | output | 1 | Illegal request |
| out_addr | output | 20 | Physical address or port number |

## Verification
The bench targets the wrap points. A 17-bit offset sum would land 64 KB too high, and a 21-bit physical sum would leak a carry past the top. It runs BP-based modes with and without override: a default-segment rule keyed on mode instead of on BP would fetch from the data window. It also checks register values with nonzero upper halves, a write issued together with a request, and writes to codes 6 and 7. A design that forwarded the new segment value, or aliased the bad codes onto a real register, would produce a wrong address on a later request. Constrained-random requests mix legal modes, illegal mode codes and illegal base/index pairs, and each one is checked against a bench model.

// File: rtl/rmag_pkg.sv
// Package: shared widths and code values for the segmented address generator.
// Assumes the segment register and the offset have the same width.
package rmag_pkg;
    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int PA_W   = SEG_W + SHIFT;
    localparam int GPR_W  = 32;
    localparam int NSEG   = 6;
    localparam int SEL_W  = $clog2(NSEG + 2);
    localparam int PORT_W = 16;

    typedef enum logic [2:0] {
        AM_DIRECT        = 3'd0,
        AM_REG           = 3'd1,
        AM_REG_DISP      = 3'd2,
        AM_BASE_IDX      = 3'd3,
        AM_BASE_IDX_DISP = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        RG_BX = 2'd0,
        RG_BP = 2'd1,
        RG_SI = 2'd2,
        RG_DI = 2'd3
    } rcode_e;

    localparam logic [SEL_W-1:0] SG_CODE  = 3'd0;
    localparam logic [SEL_W-1:0] SG_STACK = 3'd1;
    localparam logic [SEL_W-1:0] SG_DATA  = 3'd2;
endpackage

// File: rtl/rmag_seg_file.sv
// Segment register file: NSEG registers of SEG_W bits, one write port.
// Assumes write codes at or above NSEG are meaningless and are dropped.
// Reads are combinational from the current register state.
module rmag_seg_file
    import rmag_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int W  = SEG_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  seg_q [N]
);
    for (genvar k = 0; k < N; k++) begin : g_seg
        // Load one segment register when the write code names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[k] <= '0;
            else if (wr_en && (wr_sel == SW'(k)))
                seg_q[k] <= wr_data;
        end

        a_r7_seg_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SW'(k)) |=> (seg_q[k] == $past(wr_data)));

        a_r7_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_sel) >= N) |=> $stable(seg_q[k]));
    end
endmodule

// File: rtl/rmag_ea_unit.sv
// Effective-address unit: forms the 16-bit offset for the given mode.
// It also reports whether BP took part and whether the mode/register
// combination is illegal. Assumes only the low OFF_W bits of each
// general register count; the sum wraps modulo 2^OFF_W.
module rmag_ea_unit
    import rmag_pkg::*;
#(
    parameter int GW = GPR_W,
    parameter int OW = OFF_W
) (
    input  logic [2:0]    mode,
    input  logic [1:0]    reg_a,
    input  logic [1:0]    reg_b,
    input  logic [GW-1:0] bx,
    input  logic [GW-1:0] bp,
    input  logic [GW-1:0] si,
    input  logic [GW-1:0] di,
    input  logic [OW-1:0] disp,
    output logic [OW-1:0] ea,
    output logic          bp_used,
    output logic          illegal
);
    logic [OW-1:0] val_a;
    logic [OW-1:0] val_b;
    logic          a_is_base;
    logic          b_is_index;
    logic          unused_hi;

    assign unused_hi = ^{bx[GW-1:OW], bp[GW-1:OW], si[GW-1:OW], di[GW-1:OW]};

    // Select the low half of the register named by each code.
    always_comb begin
        unique case (reg_a)
            RG_BX:   val_a = bx[OW-1:0];
            RG_BP:   val_a = bp[OW-1:0];
            RG_SI:   val_a = si[OW-1:0];
            default: val_a = di[OW-1:0];
        endcase
        unique case (reg_b)
            RG_BX:   val_b = bx[OW-1:0];
            RG_BP:   val_b = bp[OW-1:0];
            RG_SI:   val_b = si[OW-1:0];
            default: val_b = di[OW-1:0];
        endcase
    end

    assign a_is_base  = (reg_a == RG_BX) || (reg_a == RG_BP);
    assign b_is_index = (reg_b == RG_SI) || (reg_b == RG_DI);

    // Per-mode offset sum, BP usage and legality.
    always_comb begin
        ea      = '0;
        bp_used = 1'b0;
        illegal = 1'b0;
        case (mode)
            AM_DIRECT: ea = disp;
            AM_REG: begin
                ea      = val_a;
                bp_used = (reg_a == RG_BP);
            end
            AM_REG_DISP: begin
                ea      = val_a + disp;
                bp_used = (reg_a == RG_BP);
            end
            AM_BASE_IDX: begin
                ea      = val_a + val_b;
                bp_used = (reg_a == RG_BP);
                illegal = !(a_is_base && b_is_index);
            end
            AM_BASE_IDX_DISP: begin
                ea      = val_a + val_b + disp;
                bp_used = (reg_a == RG_BP);
                illegal = !(a_is_base && b_is_index);
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/rmag_seg_pick.sv
// Segment chooser: override code if present, else stack when BP was used,
// else data. Flags an override code that names no segment register and
// falls back to the data code so the read index stays in range.
module rmag_seg_pick
    import rmag_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int SW = SEL_W
) (
    input  logic          ovr_en,
    input  logic [SW-1:0] ovr_sel,
    input  logic          bp_used,
    output logic [SW-1:0] seg_idx,
    output logic          bad_ovr
);
    // Resolve the segment index for this request.
    always_comb begin
        bad_ovr = 1'b0;
        if (ovr_en) begin
            if (int'(ovr_sel) < N) begin
                seg_idx = ovr_sel;
            end else begin
                seg_idx = SG_DATA;
                bad_ovr = 1'b1;
            end
        end else begin
            seg_idx = bp_used ? SG_STACK : SG_DATA;
        end
    end
endmodule

// File: rtl/rm_addr_gen.sv
// Real-mode segmented address generator, top level.
// Per request: effective address -> segment choice -> (seg<<SHIFT)+ea,
// registered one cycle after req_valid. I/O requests skip segmentation.
// Assumes a segment written in the request cycle applies only later.
module rm_addr_gen
    import rmag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic [2:0]        req_mode,
    input  logic [1:0]        req_reg_a,
    input  logic [1:0]        req_reg_b,
    input  logic              req_ovr_en,
    input  logic [SEL_W-1:0]  req_ovr_sel,
    input  logic [OFF_W-1:0]  req_disp,
    input  logic [PORT_W-1:0] req_port,
    input  logic [GPR_W-1:0]  gpr_bx,
    input  logic [GPR_W-1:0]  gpr_bp,
    input  logic [GPR_W-1:0]  gpr_si,
    input  logic [GPR_W-1:0]  gpr_di,
    output logic              out_valid,
    output logic              out_io,
    output logic              out_err,
    output logic [PA_W-1:0]   out_addr
);
    localparam int PAD   = PA_W - OFF_W;
    localparam int IOPAD = PA_W - PORT_W;

    logic [SEG_W-1:0] seg_q [NSEG];
    logic [OFF_W-1:0] ea;
    logic             bp_used;
    logic             ea_bad;
    logic [SEL_W-1:0] seg_idx;
    logic             ovr_bad;
    logic [SEG_W-1:0] seg_base;
    logic [PA_W-1:0]  phys;
    logic             req_err;

    rmag_seg_file u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    rmag_ea_unit u_ea (
        .mode    (req_mode),
        .reg_a   (req_reg_a),
        .reg_b   (req_reg_b),
        .bx      (gpr_bx),
        .bp      (gpr_bp),
        .si      (gpr_si),
        .di      (gpr_di),
        .disp    (req_disp),
        .ea      (ea),
        .bp_used (bp_used),
        .illegal (ea_bad)
    );

    rmag_seg_pick u_pick (
        .ovr_en  (req_ovr_en),
        .ovr_sel (req_ovr_sel),
        .bp_used (bp_used),
        .seg_idx (seg_idx),
        .bad_ovr (ovr_bad)
    );

    assign seg_base = seg_q[seg_idx];
    assign phys     = {seg_base, {SHIFT{1'b0}}} + {{PAD{1'b0}}, ea};
    assign req_err  = ea_bad || ovr_bad;

    // Register the result and its flags one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_io    <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= req_valid && !req_io && !req_err;
            out_io    <= req_valid && req_io;
            out_err   <= req_valid && !req_io && req_err;
            if (req_valid)
                out_addr <= req_io ? {{IOPAD{1'b0}}, req_port} : phys;
        end
    end

    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid) && !$past(req_io));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_io, out_err}));

    a_r9_io_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        out_io |-> (out_addr[PA_W-1:PORT_W] == '0));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(out_valid || out_io || out_err));
endmodule

// File: tb/rm_addr_gen_tb.sv
`timescale 1ns/1ps
module rm_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [2:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_io = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_reg_a = '0;
    logic [1:0]  req_reg_b = '0;
    logic        req_ovr_en = 1'b0;
    logic [2:0]  req_ovr_sel = '0;
    logic [15:0] req_disp = '0;
    logic [15:0] req_port = '0;
    logic [31:0] gpr_bx = '0, gpr_bp = '0, gpr_si = '0, gpr_di = '0;
    logic        out_valid, out_io, out_err;
    logic [19:0] out_addr;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] shadow [6];

    always #10 clk = ~clk;

    rm_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_io(req_io), .req_mode(req_mode),
        .req_reg_a(req_reg_a), .req_reg_b(req_reg_b),
        .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel),
        .req_disp(req_disp), .req_port(req_port),
        .gpr_bx(gpr_bx), .gpr_bp(gpr_bp), .gpr_si(gpr_si), .gpr_di(gpr_di),
        .out_valid(out_valid), .out_io(out_io), .out_err(out_err), .out_addr(out_addr)
    );

    function automatic logic [15:0] rv(input logic [1:0] c);
        case (c)
            2'd0:    return gpr_bx[15:0];
            2'd1:    return gpr_bp[15:0];
            2'd2:    return gpr_si[15:0];
            default: return gpr_di[15:0];
        endcase
    endfunction

    // Reference model of the requirements for the current stimulus.
    task automatic model(output logic v, output logic io, output logic er,
                         output logic [19:0] a);
        logic [15:0] ea;
        logic        bpu, bad;
        logic [2:0]  sg;
        ea = '0; bpu = 1'b0; bad = 1'b0;
        case (req_mode)
            3'd0: ea = req_disp;
            3'd1: begin ea = rv(req_reg_a); bpu = (req_reg_a == 2'd1); end
            3'd2: begin ea = rv(req_reg_a) + req_disp; bpu = (req_reg_a == 2'd1); end
            3'd3, 3'd4: begin
                ea = rv(req_reg_a) + rv(req_reg_b) + ((req_mode == 3'd4) ? req_disp : 16'd0);
                bpu = (req_reg_a == 2'd1);
                bad = (req_reg_a > 2'd1) || (req_reg_b < 2'd2);
            end
            default: bad = 1'b1;
        endcase
        sg = bpu ? 3'd1 : 3'd2;
        if (req_ovr_en) begin
            if (req_ovr_sel > 3'd5) bad = 1'b1;
            else sg = req_ovr_sel;
        end
        v = 0; io = 0; er = 0; a = '0;
        if (req_io) begin io = 1; a = {4'h0, req_port}; end
        else if (bad) er = 1;
        else begin
            v = 1;
            a = 20'({shadow[sg], 4'h0} + {4'h0, ea});
        end
    endtask

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Issue the current request (with any write set up alongside) and check it.
    task automatic fire(input string tag);
        logic ev, eio, eer;
        logic [19:0] ea;
        logic        wr;
        logic [2:0]  ws;
        logic [15:0] wd;
        model(ev, eio, eer, ea);
        wr = seg_wr_en; ws = seg_wr_sel; wd = seg_wr_data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seg_wr_en = 1'b0;
        if (wr && ws < 3'd6) shadow[ws] = wd;
        check({tag, " flags"}, {17'd0, out_valid, out_io, out_err}, {17'd0, ev, eio, eer});
        if (ev || eio) check({tag, " addr"}, out_addr, ea);
    endtask

    task automatic wr_seg(input logic [2:0] s, input logic [15:0] d);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = d;
        @(negedge clk);
        seg_wr_en = 1'b0;
        if (s < 3'd6) shadow[s] = d;
    endtask

    task automatic set_req(input logic [2:0] m, input logic [1:0] a, input logic [1:0] b,
                           input logic oe, input logic [2:0] os, input logic [15:0] d);
        req_io = 1'b0; req_mode = m; req_reg_a = a; req_reg_b = b;
        req_ovr_en = oe; req_ovr_sel = os; req_disp = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 6; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state, and zero segments after reset
        check("R12 reset flags", {17'd0, out_valid, out_io, out_err}, 20'd0);
        check("R12 reset addr", out_addr, 20'd0);
        set_req(3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 16'h1234);
        fire("R12 zero segment");
        @(negedge clk);
        check("R12 idle flags", {17'd0, out_valid, out_io, out_err}, 20'd0);

        // R1: basic shift-and-add, and the 20-bit wrap
        wr_seg(3'd0, 16'h1000);
        set_req(3'd0, 2'd0, 2'd0, 1'b1, 3'd0, 16'h0100);
        fire("R1 code window");
        wr_seg(3'd2, 16'hFFFF);
        set_req(3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 16'hFFFF);
        fire("R1 wrap 2^20");

        // R2/R5: BP-based access defaults to stack; upper halves ignored
        wr_seg(3'd1, 16'h2000);
        gpr_bp = 32'h0000F000;
        set_req(3'd1, 2'd1, 2'd0, 1'b0, 3'd0, 16'h0);
        fire("R5 BP default stack");
        gpr_bp = 32'hFFFFF000;
        fire("R2 BP upper half");
        wr_seg(3'd2, 16'h3000);
        gpr_si = 32'h0001000E;
        set_req(3'd1, 2'd2, 2'd0, 1'b0, 3'd0, 16'h0);
        fire("R2 SI low half");
        set_req(3'd4, 2'd1, 2'd2, 1'b0, 3'd0, 16'h0010);
        fire("R5 BP+SI+disp stack");
        set_req(3'd3, 2'd0, 2'd2, 1'b0, 3'd0, 16'h0);
        fire("R5 BX+SI data");

        // R6: override replaces default
        wr_seg(3'd3, 16'h4000);
        gpr_bx = 32'hABCD1234;
        set_req(3'd1, 2'd0, 2'd0, 1'b1, 3'd3, 16'h0);
        fire("R6 extra override");
        set_req(3'd2, 2'd1, 2'd0, 1'b1, 3'd2, 16'h0004);
        fire("R6 BP with data override");

        // R3: each mode on a known layout
        wr_seg(3'd2, 16'h0B00);
        gpr_si = 32'h100; gpr_di = 32'h200; gpr_bx = 32'h300;
        set_req(3'd1, 2'd3, 2'd0, 1'b0, 3'd0, 16'h0);     fire("R3 mode1 DI");
        set_req(3'd2, 2'd0, 2'd0, 1'b0, 3'd0, 16'h0400);  fire("R3 mode2 BX+disp");
        set_req(3'd2, 2'd3, 2'd0, 1'b0, 3'd0, 16'h0400);  fire("R3 mode2 DI+disp");
        set_req(3'd3, 2'd0, 2'd3, 1'b0, 3'd0, 16'h0);     fire("R3 mode3 BX+DI");
        set_req(3'd4, 2'd0, 2'd3, 1'b0, 3'd0, 16'h0400);  fire("R3 mode4 BX+DI+disp");
        check("R3 example value", 20'h0B900, 20'({16'h0B00, 4'h0} + 20'h900));

        // R4: offset wraps modulo 2^16
        gpr_bx = 32'h0000FFFF;
        set_req(3'd2, 2'd0, 2'd0, 1'b0, 3'd0, 16'h0002);
        fire("R4 ea wrap");
        set_req(3'd4, 2'd0, 2'd3, 1'b0, 3'd0, 16'hFFFF);
        fire("R4 triple wrap");

        // R11: aliasing pairs
        wr_seg(3'd2, 16'h002B);
        wr_seg(3'd3, 16'h002C);
        set_req(3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 16'h0013);
        fire("R11 alias A");
        check("R11 alias A value", out_addr, 20'h002C3);
        set_req(3'd0, 2'd0, 2'd0, 1'b1, 3'd3, 16'h0003);
        fire("R11 alias B");
        check("R11 alias B value", out_addr, 20'h002C3);

        // R7: writes to codes 6 and 7 change nothing
        wr_seg(3'd4, 16'h0550); wr_seg(3'd5, 16'h0660);
        wr_seg(3'd6, 16'h1234); wr_seg(3'd7, 16'h4321);
        for (int s = 0; s < 6; s++) begin
            set_req(3'd0, 2'd0, 2'd0, 1'b1, 3'(s), 16'h0007);
            fire("R7 segment readback");
        end

        // R8: same-cycle write uses old value, next request sees new
        set_req(3'd0, 2'd0, 2'd0, 1'b1, 3'd4, 16'h0001);
        seg_wr_en = 1'b1; seg_wr_sel = 3'd4; seg_wr_data = 16'h7770;
        fire("R8 old value same cycle");
        check("R8 old value", out_addr, 20'h05501);
        fire("R8 new value next");
        check("R8 new value", out_addr, 20'h77701);

        // R9: I/O path
        req_io = 1'b1; req_port = 16'hFFFF; req_mode = 3'd7;
        fire("R9 io top port");
        req_port = 16'h0000;
        fire("R9 io port zero");
        req_io = 1'b0;

        // R10: illegal combinations
        set_req(3'd3, 2'd0, 2'd1, 1'b0, 3'd0, 16'h0);  fire("R10 two bases");
        set_req(3'd4, 2'd2, 2'd3, 1'b0, 3'd0, 16'h0);  fire("R10 two indexes");
        set_req(3'd5, 2'd0, 2'd0, 1'b0, 3'd0, 16'h0);  fire("R10 mode5");
        set_req(3'd7, 2'd0, 2'd0, 1'b0, 3'd0, 16'h0);  fire("R10 mode7");
        set_req(3'd0, 2'd0, 2'd0, 1'b1, 3'd6, 16'h0);  fire("R10 bad override");

        // Random mix over R1..R10
        for (int i = 0; i < 600; i++) begin
            gpr_bx = $urandom; gpr_bp = $urandom; gpr_si = $urandom; gpr_di = $urandom;
            set_req(3'($urandom % 8), 2'($urandom), 2'($urandom),
                    1'(($urandom % 3) == 0), 3'($urandom % 8), 16'($urandom));
            req_io = (($urandom % 10) == 0);
            req_port = 16'($urandom);
            if (($urandom % 4) == 0) begin
                seg_wr_en = 1'b1; seg_wr_sel = 3'($urandom % 8); seg_wr_data = 16'($urandom);
            end
            fire("R1/R3/R5/R6/R8 random");
            if (($urandom % 5) == 0) begin
                @(negedge clk);
                check("R12 random idle", {17'd0, out_valid, out_io, out_err}, 20'd0);
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule